// File: doc/BRIEF.md
# Chain Tag Sequencer with Return-Address Stack

This block steps a source-chain DMA through its linked list of tags. For every tag that the fetch logic hands over, it works out where the payload data sits, where the next tag will be read from, and whether the chain stops after this tag. The fetch logic supplies the tag's kind (a 3-bit code), its quadword count, its 32-bit address field and the address the tag itself was read from. The block returns the data pointer, the next tag pointer, an end flag and an overflow flag, all registered and qualified by a one-cycle `done` pulse.

Two of the eight tag kinds implement subroutines in the list. A call kind saves the address just past its own payload on a two-entry return stack and jumps to its address field. A return kind pops the most recent saved address and continues there. An empty stack on return ends the chain. A full stack on call is an overflow, which also ends the chain. A per-request `stack_en` input lets channels that have no stack hardware share the block. For such requests the call and return kinds are treated as unrecognised and have no effect.

Every tag kind is decoded in one cycle. The stack depth is brought out so that the surrounding channel logic can see how many return addresses are pending.

Top module: `dma_tag_seq`

## Requirements
- R1: After reset, `data_addr`, `next_tag_ptr`, `done`, `chain_end`, `overflow` and `stack_depth` are all zero.
- R2: A request sampled at a rising edge produces `done`=1 for exactly the following cycle, together with that tag's `chain_end` and `overflow`. `done` is 0 in a cycle that follows no request.
- R3: Count kind (code 1): `data_addr` = `cur_tag_ptr`+16 and `next_tag_ptr` = `cur_tag_ptr`+16+16×`tag_qwc`. The chain continues.
- R4: Jump kind (code 2): `data_addr` = `cur_tag_ptr`+16 and `next_tag_ptr` = `tag_addr`. The chain continues.
- R5: Reference kinds (codes 3 and 4): `data_addr` = `tag_addr` and `next_tag_ptr` = `cur_tag_ptr`+16. The chain continues.
- R6: Reference-and-stop kind (code 0): `data_addr` = `tag_addr`, `next_tag_ptr` = `cur_tag_ptr`, and `chain_end`=1.
- R7: Stop kind (code 7): `data_addr` = `cur_tag_ptr`+16, `next_tag_ptr` = `cur_tag_ptr` (not advanced), and `chain_end`=1.
- R8: Call kind (code 5) with `stack_en`=1 and depth below 2: `data_addr` = `cur_tag_ptr`+16 and `next_tag_ptr` = `tag_addr`. The address `cur_tag_ptr`+16+16×`tag_qwc` is pushed and `stack_depth` rises by one.
- R9: Call kind with depth already 2: `chain_end`=1 and `overflow`=1. The stack is unchanged and `next_tag_ptr` = `cur_tag_ptr`.
- R10: Return kind (code 6) with `stack_en`=1 and depth 1 or 2: `data_addr` = `cur_tag_ptr`+16. `next_tag_ptr` takes the most recently pushed address and `stack_depth` drops by one (last in, first out).
- R11: Return kind with depth 0: `data_addr` = `cur_tag_ptr`+16, `next_tag_ptr` = `cur_tag_ptr`, `chain_end`=1, `overflow`=0.
- R12: With `stack_en`=0, codes 5 and 6 leave `data_addr`, `next_tag_ptr` and `stack_depth` unchanged and give `chain_end`=0 and `overflow`=0. `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Decode the tag presented this cycle |
| tag_id | input | 3 | Tag kind code |
| tag_qwc | input | 16 | Payload length in quadwords |
| tag_addr | input | 32 | Address field of the tag |
| cur_tag_ptr | input | 32 | Address the tag was read from |
| stack_en | input | 1 | Channel has a return-address stack |
| data_addr | output | 32 | Start address of this tag's payload |
| next_tag_ptr | output | 32 | Address of the next tag to fetch |
| done | output | 1 | One-cycle pulse: results valid |
| chain_end | output | 1 | Chain stops after this tag |
| overflow | output | 1 | Call issued with a full stack |
| stack_depth | output | 2 | Number of saved return addresses |

## Verification
The bound checker watches on every cycle that `done` follows each request by one cycle and never appears without one, that the depth never exceeds two, and that overflow never shows without an end. It also checks that the count and stop kinds produce their pointers from the previous cycle's tag address, that a call with room raises the depth by one, and that a return on an empty stack ends the chain. Only the bench's scenarios can show the last-in-first-out order of nested calls and returns, the exact return addresses, the hold behaviour across disabled-stack requests, and the clearing of the pending stack by reset.

// File: rtl/dma_tag_pkg.sv
package dma_tag_pkg;

  typedef enum logic [2:0] {
    TAG_REF_LAST  = 3'd0,
    TAG_COUNT     = 3'd1,
    TAG_JUMP      = 3'd2,
    TAG_REF_DATA  = 3'd3,
    TAG_REF_STALL = 3'd4,
    TAG_CALL      = 3'd5,
    TAG_RETURN    = 3'd6,
    TAG_STOP      = 3'd7
  } tag_kind_e;

  localparam int unsigned QW_BYTES_LOG2 = 4;

endpackage

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_tag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned QW    = 16,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic [2:0]    tag_id,
  input  logic [QW-1:0] tag_qwc,
  input  logic [AW-1:0] tag_addr,
  input  logic [AW-1:0] cur_ptr,
  input  logic          stack_en,
  input  logic [PW-1:0] depth,
  input  logic [AW-1:0] pop_data,
  output logic          upd,
  output logic [AW-1:0] nxt_data,
  output logic [AW-1:0] nxt_tag,
  output logic          end_o,
  output logic          ovf_o,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] push_data
);

  localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_BYTES_LOG2;

  function automatic logic [AW-1:0] after_tag(input logic [AW-1:0] p);
    return p + QW_BYTES;
  endfunction

  function automatic logic [AW-1:0] past_payload(input logic [AW-1:0] base,
                                                 input logic [QW-1:0] n);
    logic [AW-1:0] span;
    span = AW'(n) << QW_BYTES_LOG2;
    return base + span;
  endfunction

  logic          stk_full;
  logic          stk_has;
  logic [AW-1:0] body;

  assign stk_full = (depth >= PW'(DEPTH));
  assign stk_has  = (depth != '0) && (depth <= PW'(DEPTH));
  assign body     = after_tag(cur_ptr);

  always_comb begin
    upd       = 1'b1;
    nxt_data  = body;
    nxt_tag   = cur_ptr;
    end_o     = 1'b0;
    ovf_o     = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = past_payload(body, tag_qwc);
    unique case (tag_kind_e'(tag_id))
      TAG_REF_LAST: begin
        nxt_data = tag_addr;
        end_o    = 1'b1;
      end
      TAG_COUNT: begin
        nxt_tag = past_payload(body, tag_qwc);
      end
      TAG_JUMP: begin
        nxt_tag = tag_addr;
      end
      TAG_REF_DATA, TAG_REF_STALL: begin
        nxt_data = tag_addr;
        nxt_tag  = body;
      end
      TAG_CALL: begin
        if (!stack_en) begin
          upd = 1'b0;
        end else if (stk_full) begin
          end_o = 1'b1;
          ovf_o = 1'b1;
        end else begin
          push    = 1'b1;
          nxt_tag = tag_addr;
        end
      end
      TAG_RETURN: begin
        if (!stack_en) begin
          upd = 1'b0;
        end else if (stk_has) begin
          pop     = 1'b1;
          nxt_tag = pop_data;
        end else begin
          end_o = 1'b1;
        end
      end
      TAG_STOP: begin
        end_o = 1'b1;
      end
      default: begin
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dma_ret_stack.sv
module dma_ret_stack #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [PW-1:0] depth,
  output logic [AW-1:0] top_data
);

  logic [AW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (push && depth == PW'(g)) begin
        slot[g] <= push_data;
      end else if (pop && depth == PW'(g + 1)) begin
        slot[g] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push) begin
      depth <= depth + PW'(1);
    end else if (pop) begin
      depth <= depth - PW'(1);
    end
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == PW'(i + 1)) top_data = slot[i];
    end
  end

endmodule

// File: rtl/dma_tag_seq.sv
module dma_tag_seq #(
  parameter int unsigned AW    = 32,
  parameter int unsigned QW    = 16,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    tag_id,
  input  logic [QW-1:0] tag_qwc,
  input  logic [AW-1:0] tag_addr,
  input  logic [AW-1:0] cur_tag_ptr,
  input  logic          stack_en,
  output logic [AW-1:0] data_addr,
  output logic [AW-1:0] next_tag_ptr,
  output logic          done,
  output logic          chain_end,
  output logic          overflow,
  output logic [PW-1:0] stack_depth
);

  logic          dec_upd;
  logic [AW-1:0] dec_data;
  logic [AW-1:0] dec_tag;
  logic          dec_end;
  logic          dec_ovf;
  logic          dec_push;
  logic          dec_pop;
  logic [AW-1:0] dec_push_data;
  logic [AW-1:0] stk_top;
  logic          stk_push;
  logic          stk_pop;

  dma_tag_decode #(.AW(AW), .QW(QW), .DEPTH(DEPTH), .PW(PW)) u_dec (
    .tag_id    (tag_id),
    .tag_qwc   (tag_qwc),
    .tag_addr  (tag_addr),
    .cur_ptr   (cur_tag_ptr),
    .stack_en  (stack_en),
    .depth     (stack_depth),
    .pop_data  (stk_top),
    .upd       (dec_upd),
    .nxt_data  (dec_data),
    .nxt_tag   (dec_tag),
    .end_o     (dec_end),
    .ovf_o     (dec_ovf),
    .push      (dec_push),
    .pop       (dec_pop),
    .push_data (dec_push_data)
  );

  assign stk_push = req && dec_push;
  assign stk_pop  = req && dec_pop;

  dma_ret_stack #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (dec_push_data),
    .depth     (stack_depth),
    .top_data  (stk_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_addr    <= '0;
      next_tag_ptr <= '0;
      done         <= 1'b0;
      chain_end    <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        chain_end <= dec_end;
        overflow  <= dec_ovf;
        if (dec_upd) begin
          data_addr    <= dec_data;
          next_tag_ptr <= dec_tag;
        end
      end else begin
        chain_end <= 1'b0;
        overflow  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_tag_seq_chk.sv
module dma_tag_seq_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [2:0]    tag_id,
  input logic [AW-1:0] cur_tag_ptr,
  input logic          stack_en,
  input logic [AW-1:0] data_addr,
  input logic [AW-1:0] next_tag_ptr,
  input logic          done,
  input logic          chain_end,
  input logic          overflow,
  input logic [PW-1:0] stack_depth
);

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done); // R2
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done); // R2
  AST_COUNT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req && tag_id == 3'd1) |=> (data_addr == $past(cur_tag_ptr) + AW'(16)) && !chain_end); // R3
  AST_STOP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && tag_id == 3'd7) |=> (next_tag_ptr == $past(cur_tag_ptr)) && chain_end); // R7
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= PW'(DEPTH)); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && stack_en && tag_id == 3'd5 && stack_depth < PW'(DEPTH))
      |=> stack_depth == $past(stack_depth) + PW'(1)); // R8
  AST_OVF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (chain_end && done)); // R9
  AST_RET_EMPTY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && stack_en && tag_id == 3'd6 && stack_depth == '0) |=> chain_end && !overflow); // R11
  AST_NO_STACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stack_en && (tag_id == 3'd5 || tag_id == 3'd6))
      |=> $stable(data_addr) && $stable(next_tag_ptr) && $stable(stack_depth) && !chain_end); // R12

endmodule

bind dma_tag_seq dma_tag_seq_chk #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .tag_id       (tag_id),
  .cur_tag_ptr  (cur_tag_ptr),
  .stack_en     (stack_en),
  .data_addr    (data_addr),
  .next_tag_ptr (next_tag_ptr),
  .done         (done),
  .chain_end    (chain_end),
  .overflow     (overflow),
  .stack_depth  (stack_depth)
);

// File: tb/dma_tag_seq_tb.sv
module dma_tag_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  tag_id = '0;
  logic [15:0] tag_qwc = '0;
  logic [31:0] tag_addr = '0;
  logic [31:0] cur_tag_ptr = '0;
  logic        stack_en = 1'b0;
  logic [31:0] data_addr;
  logic [31:0] next_tag_ptr;
  logic        done;
  logic        chain_end;
  logic        overflow;
  logic [1:0]  stack_depth;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dma_tag_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .tag_id(tag_id), .tag_qwc(tag_qwc),
    .tag_addr(tag_addr), .cur_tag_ptr(cur_tag_ptr), .stack_en(stack_en),
    .data_addr(data_addr), .next_tag_ptr(next_tag_ptr), .done(done),
    .chain_end(chain_end), .overflow(overflow), .stack_depth(stack_depth)
  );

  typedef struct packed {
    logic [2:0]  id;
    logic [15:0] qwc;
    logic [31:0] addr;
    logic [31:0] cur;
    logic        en;
    logic [31:0] e_data;
    logic [31:0] e_tag;
    logic        e_end;
    logic        e_ovf;
    logic [1:0]  e_dep;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 16'd4,      32'h0,    32'h1000, 1'b1, 32'h1010, 32'h1050,   1'b0, 1'b0, 2'd0, 4'd3},
    '{3'd2, 16'd2,      32'h2000, 32'h1050, 1'b1, 32'h1060, 32'h2000,   1'b0, 1'b0, 2'd0, 4'd4},
    '{3'd3, 16'd3,      32'h8000, 32'h2000, 1'b1, 32'h8000, 32'h2010,   1'b0, 1'b0, 2'd0, 4'd5},
    '{3'd4, 16'd3,      32'h9000, 32'h2010, 1'b1, 32'h9000, 32'h2020,   1'b0, 1'b0, 2'd0, 4'd5},
    '{3'd5, 16'd2,      32'h3000, 32'h2020, 1'b1, 32'h2030, 32'h3000,   1'b0, 1'b0, 2'd1, 4'd8},
    '{3'd5, 16'd1,      32'h4000, 32'h3000, 1'b1, 32'h3010, 32'h4000,   1'b0, 1'b0, 2'd2, 4'd8},
    '{3'd5, 16'd1,      32'h5000, 32'h4000, 1'b1, 32'h4010, 32'h4000,   1'b1, 1'b1, 2'd2, 4'd9},
    '{3'd6, 16'd0,      32'h0,    32'h4000, 1'b1, 32'h4010, 32'h3020,   1'b0, 1'b0, 2'd1, 4'd10},
    '{3'd6, 16'd0,      32'h0,    32'h3020, 1'b1, 32'h3030, 32'h2050,   1'b0, 1'b0, 2'd0, 4'd10},
    '{3'd6, 16'd0,      32'h0,    32'h2050, 1'b1, 32'h2060, 32'h2050,   1'b1, 1'b0, 2'd0, 4'd11},
    '{3'd0, 16'd5,      32'h7000, 32'h2050, 1'b1, 32'h7000, 32'h2050,   1'b1, 1'b0, 2'd0, 4'd6},
    '{3'd7, 16'd5,      32'h0ABC, 32'h6000, 1'b1, 32'h6010, 32'h6000,   1'b1, 1'b0, 2'd0, 4'd7},
    '{3'd5, 16'd1,      32'h0001, 32'h7777, 1'b0, 32'h6010, 32'h6000,   1'b0, 1'b0, 2'd0, 4'd12},
    '{3'd6, 16'd1,      32'h0001, 32'h7777, 1'b0, 32'h6010, 32'h6000,   1'b0, 1'b0, 2'd0, 4'd12},
    '{3'd5, 16'd0,      32'hA000, 32'h0100, 1'b1, 32'h0110, 32'hA000,   1'b0, 1'b0, 2'd1, 4'd8},
    '{3'd6, 16'd0,      32'h0,    32'hA000, 1'b0, 32'h0110, 32'hA000,   1'b0, 1'b0, 2'd1, 4'd12},
    '{3'd6, 16'd0,      32'h0,    32'hA000, 1'b1, 32'hA010, 32'h0110,   1'b0, 1'b0, 2'd0, 4'd10},
    '{3'd1, 16'hFFFF,   32'h0,    32'h0,    1'b1, 32'h0010, 32'h100000, 1'b0, 1'b0, 2'd0, 4'd3}
  };

  function automatic string rtag(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string rq, input logic [69:0] act, input logic [69:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [69:0] outs();
    return {data_addr, next_tag_ptr, done, chain_end, overflow, stack_depth, 1'b0};
  endfunction

  task automatic issue(input logic [2:0] id, input logic [15:0] q,
                       input logic [31:0] a, input logic [31:0] c, input logic en);
    @(negedge clk);
    req = 1'b1; tag_id = id; tag_qwc = q; tag_addr = a; cur_tag_ptr = c; stack_en = en;
    @(negedge clk);
    req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", outs(), 70'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].id, VEC[i].qwc, VEC[i].addr, VEC[i].cur, VEC[i].en);
      check(rtag(int'(VEC[i].rq)), outs(),
            {VEC[i].e_data, VEC[i].e_tag, 1'b1, VEC[i].e_end, VEC[i].e_ovf, VEC[i].e_dep, 1'b0});
    end

    // R2: done and flags drop in an idle cycle
    @(negedge clk);
    check("R2", {68'd0, done, chain_end}, 70'd0);

    // R2: back-to-back requests each give a done pulse
    @(negedge clk);
    req = 1'b1; tag_id = 3'd7; tag_qwc = '0; tag_addr = '0; cur_tag_ptr = 32'h500; stack_en = 1'b1;
    @(negedge clk);
    tag_id = 3'd2; tag_addr = 32'h900; cur_tag_ptr = 32'h600;
    check("R2", {next_tag_ptr, 36'd0, done, chain_end}, {32'h500, 36'd0, 1'b1, 1'b1});
    @(negedge clk);
    req = 1'b0;
    check("R2", {next_tag_ptr, 36'd0, done, chain_end}, {32'h900, 36'd0, 1'b1, 1'b0});

    // R1: reset empties a pending stack; a following return then ends
    issue(3'd5, 16'd0, 32'hB000, 32'h0, 1'b1);
    issue(3'd5, 16'd0, 32'hC000, 32'h0, 1'b1);
    check("R8", {68'd0, stack_depth}, {68'd0, 2'd2});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", outs(), 70'd0);
    issue(3'd6, 16'd0, 32'h0, 32'h40, 1'b1);
    check("R11", outs(), {32'h50, 32'h40, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule